// File: doc/BRIEF.md
# Modulo-7 Split Booth Multiplier

This block multiplies a signed data word by a signed coefficient and registers the full-width two's-complement product. The coefficient is cut into radix-32 Booth digits, each in -16..+16. Each digit is then split into a high and a low secondary digit, and each secondary digit is a power of two of at most four, or zero. Because of this, every partial-product row is the data word shifted and perhaps complemented. No odd multiple such as 3x needs an adder ahead of the reduction.

The high digit carries weight seven. Each high digit therefore becomes two rows: one shifted three places further left, and one with the opposite sign. All rows go through a chain of 3:2 carry-save compressors. A small word that gathers the +1 carries of the complemented rows joins them there, and one final adder produces the product. The coefficient recoder depends only on the coefficient, so a coefficient that stays fixed keeps it off the data-to-product path.

Top module: `smr_mult`

## Requirements
- R1: While rst_ni is low, prod_o reads zero whatever the inputs.
- R2: At every rising clock edge with reset released, prod_o takes the exact signed product of data_i and coef_i sampled at that edge. The result is DW+CW bits wide, with no truncation and no overflow.
- R3: Booth digit j is -16·b(5j+4) + 8·b(5j+3) + 4·b(5j+2) + 2·b(5j+1) + b(5j) + b(5j-1) of the coefficient bits b. Here b(-1) is 0 and bits above CW-1 copy the sign bit, so the digits weighted by 32^j add up to the signed coefficient.
- R4: Every Booth digit equals 7·hi + lo. Here lo is taken from {0, ±1, ±2, ±4} and hi from {0, ±1, ±2}.
- R5: A secondary digit is coded as {neg, zero, sh[1:0]}. Its value is 0 when zero is 1, and otherwise (neg ? -1 : +1)·2^sh. A zero digit always has neg cleared.
- R6: The most negative data word times the most negative coefficient gives +2^(DW+CW-2). Values of -1, 0, +1 and the maximum positive values also give exact results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | DW | Signed data operand |
| coef_i | input | CW | Signed coefficient operand |
| prod_o | output | DW+CW | Registered signed product |

## Verification
The bench builds the block twice: once at the default 19-by-19 size and once at 6-by-6. The narrow copy has only 4096 operand pairs, so every pair is tried, including all sign and all digit-boundary combinations of a two-digit coefficient. The wide copy runs edge values and a pseudo-random sweep against a 64-bit reference. A separate copy of the recoder is stepped through all 64 values of one six-bit digit window. Each resulting split is checked for its value, its range and the coding of zero, and random coefficients are rebuilt from all four digits.

// File: rtl/smr_pkg.sv
package smr_pkg;

  typedef struct packed {
    logic       neg;
    logic       zero;
    logic [1:0] sh;
  } sd_t;

  typedef struct packed {
    sd_t hi;
    sd_t lo;
  } dig_t;

  function automatic logic sd_ok(int v);
    return (v == 0) || (v == 1) || (v == -1) || (v == 2) || (v == -2) ||
           (v == 4) || (v == -4);
  endfunction

  function automatic sd_t sd_enc(int v);
    sd_t r;
    int  m;
    m      = (v < 0) ? -v : v;
    r.neg  = (v < 0);
    r.zero = (v == 0);
    r.sh   = (m == 4) ? 2'd2 : (m == 2) ? 2'd1 : 2'd0;
    return r;
  endfunction

  function automatic int sd_val(sd_t s);
    int m;
    m = 1 << s.sh;
    if (s.zero) return 0;
    return s.neg ? -m : m;
  endfunction

  // search hi in -2..2 so that the remainder lands in the secondary set
  function automatic dig_t split_digit(int d);
    dig_t r;
    r.hi = sd_enc(0);
    r.lo = sd_enc(0);
    for (int h = 2; h >= -2; h--) begin
      if (sd_ok(d - 7 * h)) begin
        r.hi = sd_enc(h);
        r.lo = sd_enc(d - 7 * h);
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/smr_recoder.sv
module smr_recoder
  import smr_pkg::*;
#(
  parameter int CW = 19,
  parameter int ND = (CW + 4) / 5
) (
  input  logic [CW-1:0] coef_i,
  output dig_t [ND-1:0] dig_o
);

  localparam int XW = 5 * ND + 1;

  logic [XW-1:0] cx;
  assign cx = {(XW-1)'($signed(coef_i)), 1'b0};

  for (genvar j = 0; j < ND; j++) begin : g_dig
    logic [5:0] win;
    assign win      = cx[5*j+5 -: 6];
    assign dig_o[j] = split_digit(int'($signed(win[5:1])) + int'(win[0]));
  end

endmodule

// File: rtl/smr_term.sv
module smr_term
  import smr_pkg::*;
#(
  parameter int DW   = 19,
  parameter int PW   = 38,
  parameter int BASE = 0,
  parameter bit FLIP = 1'b0
) (
  input  logic [DW-1:0] x_i,
  input  sd_t           ctl_i,
  output logic [PW-1:0] term_o,
  output logic          cin_o
);

  logic [PW-1:0] xe, mag;
  logic          neg;

  assign xe     = PW'($signed(x_i));
  assign neg    = ctl_i.neg ^ FLIP;
  assign mag    = xe << (BASE + int'(ctl_i.sh));
  // ones complement here; the +1 is gathered in the correction row
  assign term_o = ctl_i.zero ? '0 : (neg ? ~mag : mag);
  assign cin_o  = neg & ~ctl_i.zero;

endmodule

// File: rtl/smr_csa.sv
module smr_csa #(
  parameter int W = 38
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  output logic [W-1:0] s_o,
  output logic [W-1:0] cy_o
);

  assign s_o  = a_i ^ b_i ^ c_i;
  assign cy_o = ((a_i & b_i) | (a_i & c_i) | (b_i & c_i)) << 1;

endmodule

// File: rtl/smr_mult.sv
module smr_mult
  import smr_pkg::*;
#(
  parameter int DW = 19,
  parameter int CW = 19
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [DW-1:0]        data_i,
  input  logic [CW-1:0]        coef_i,
  output logic [DW+CW-1:0]     prod_o
);

  localparam int ND = (CW + 4) / 5;
  localparam int PW = DW + CW;
  localparam int NC = 3 * ND;
  localparam int NT = NC + 1;

  dig_t [ND-1:0] dig;

  smr_recoder #(.CW(CW), .ND(ND)) u_rec (
    .coef_i (coef_i),
    .dig_o  (dig)
  );

  logic [PW-1:0] term [NT];
  logic [NC-1:0] cin;
  logic [PW-1:0] corr;

  for (genvar j = 0; j < ND; j++) begin : g_rows
    smr_term #(.DW(DW), .PW(PW), .BASE(5*j), .FLIP(1'b0)) u_lo (
      .x_i (data_i), .ctl_i (dig[j].lo), .term_o (term[3*j]), .cin_o (cin[3*j])
    );
    // 7*hi = 8*hi - hi
    smr_term #(.DW(DW), .PW(PW), .BASE(5*j+3), .FLIP(1'b0)) u_hi8 (
      .x_i (data_i), .ctl_i (dig[j].hi), .term_o (term[3*j+1]), .cin_o (cin[3*j+1])
    );
    smr_term #(.DW(DW), .PW(PW), .BASE(5*j), .FLIP(1'b1)) u_hi1 (
      .x_i (data_i), .ctl_i (dig[j].hi), .term_o (term[3*j+2]), .cin_o (cin[3*j+2])
    );
  end

  always_comb begin
    corr = '0;
    for (int k = 0; k < NC; k++) corr = corr + PW'(cin[k]);
  end
  assign term[NT-1] = corr;

  logic [PW-1:0] acc_s [1:NT-1];
  logic [PW-1:0] acc_c [1:NT-1];

  assign acc_s[1] = term[0];
  assign acc_c[1] = term[1];

  for (genvar i = 2; i < NT; i++) begin : g_csa
    smr_csa #(.W(PW)) u_csa (
      .a_i  (acc_s[i-1]),
      .b_i  (acc_c[i-1]),
      .c_i  (term[i]),
      .s_o  (acc_s[i]),
      .cy_o (acc_c[i])
    );
  end

  logic [PW-1:0] sum;
  assign sum = acc_s[NT-1] + acc_c[NT-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prod_o <= '0;
    else         prod_o <= sum;
  end

  // checks on recoder output against the raw coefficient
  longint rec_sum;
  logic   rng_ok, zero_ok;
  always_comb begin
    rec_sum = 0;
    rng_ok  = 1'b1;
    zero_ok = 1'b1;
    for (int j = 0; j < ND; j++) begin
      rec_sum = rec_sum + longint'(7 * sd_val(dig[j].hi) + sd_val(dig[j].lo)) * (longint'(1) << (5 * j));
      if (dig[j].hi.sh[1] || dig[j].lo.sh == 2'd3) rng_ok = 1'b0;
      if ((dig[j].hi.zero && dig[j].hi.neg) || (dig[j].lo.zero && dig[j].lo.neg)) zero_ok = 1'b0;
    end
  end

  p_digit_sum_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_sum == longint'($signed(coef_i)));

  p_split_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rng_ok);

  p_zero_clean_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_ok);

  p_product_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> longint'($signed(prod_o)) ==
      $past(longint'($signed(data_i))) * $past(longint'($signed(coef_i))));

  p_extreme_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(data_i) == {1'b1, {(DW-1){1'b0}}} &&
     $past(coef_i) == {1'b1, {(CW-1){1'b0}}})
      |-> prod_o == (PW'(1) << (PW - 2)));

endmodule

// File: tb/tb_smr_mult.sv
`timescale 1ns/1ps
module tb_smr_mult;
  import smr_pkg::*;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic [18:0] data_b = '0, coef_b = '0;
  logic [37:0] prod_b;
  logic [5:0]  data_s = '0, coef_s = '0;
  logic [11:0] prod_s;
  logic [18:0] coef_r = '0;
  dig_t [3:0]  dig_r;

  smr_mult #(.DW(19), .CW(19)) dut (
    .clk_i (clk), .rst_ni (rst_ni), .data_i (data_b), .coef_i (coef_b), .prod_o (prod_b)
  );
  smr_mult #(.DW(6), .CW(6)) dut_s (
    .clk_i (clk), .rst_ni (rst_ni), .data_i (data_s), .coef_i (coef_s), .prod_o (prod_s)
  );
  smr_recoder #(.CW(19), .ND(4)) rec (.coef_i (coef_r), .dig_o (dig_r));

  int n_tot = 0, n_bad = 0;
  logic [31:0] seed = 32'h1234_5678;

  task automatic chk(string req, longint act, longint exp);
    n_tot++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic longint rnd19();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return longint'($signed(seed[18:0]));
  endfunction

  // value of a secondary digit from its coding (R5)
  function automatic int code_val(sd_t s);
    if (s.zero) return 0;
    return s.neg ? -(1 << s.sh) : (1 << s.sh);
  endfunction

  task automatic run_both(longint a, longint b, longint as, longint bs, string req);
    @(negedge clk);
    data_b = 19'(a); coef_b = 19'(b);
    data_s = 6'(as); coef_s = 6'(bs);
    @(negedge clk);
    chk(req, longint'($signed(prod_b)), a * b);
    chk(req, longint'($signed(prod_s)), as * bs);
  endtask

  initial begin
    #(5ns * 200000);
    n_tot++; n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end

  initial begin
    longint corner [6];
    corner[0] = -262144; corner[1] = 262143; corner[2] = -1;
    corner[3] = 0;       corner[4] = 1;      corner[5] = 87381;

    // R1: inputs active during reset, output must stay zero
    data_b = 19'd1234; coef_b = 19'd777; data_s = 6'd13; coef_s = 6'd21;
    repeat (3) @(negedge clk);
    chk("R1", longint'(prod_b), 0);
    chk("R1", longint'(prod_s), 0);
    @(negedge clk);
    rst_ni = 1'b1;

    // R2: exhaustive narrow sweep
    for (int a = -32; a < 32; a++)
      for (int b = -32; b < 32; b++)
        run_both(rnd19(), rnd19(), a, b, "R2");

    // R6: edge values on the wide copy
    for (int i = 0; i < 6; i++)
      for (int k = 0; k < 6; k++)
        run_both(corner[i], corner[k], 0, 0, "R6");
    run_both(-262144, -262144, -32, -32, "R6");
    chk("R6", longint'(prod_b), 64'sd1 << 36);

    // R3 R4 R5: every value of one digit window
    for (int k = 0; k < 64; k++) begin
      int v, hv, lv;
      coef_r = 19'(k) << 4;
      #1;
      v  = ((k >> 1) - ((k & 32) != 0 ? 32 : 0)) + (k & 1);
      hv = code_val(dig_r[1].hi);
      lv = code_val(dig_r[1].lo);
      chk("R4", longint'(7 * hv + lv), longint'(v));
      chk("R4", longint'(hv >= -2 && hv <= 2), 1);
      chk("R4", longint'(lv == 0 || lv == 1 || lv == -1 || lv == 2 || lv == -2 || lv == 4 || lv == -4), 1);
      chk("R5", longint'((dig_r[1].hi.zero & dig_r[1].hi.neg) | (dig_r[1].lo.zero & dig_r[1].lo.neg)), 0);
      chk("R5", longint'(dig_r[1].hi.neg), longint'(hv < 0));
      chk("R3", longint'(7 * code_val(dig_r[0].hi) + code_val(dig_r[0].lo)), (k & 1) ? -16 : 0);
    end

    // R3: digits weighted by 32^j rebuild random coefficients
    for (int n = 0; n < 300; n++) begin
      longint c, s;
      c = rnd19();
      coef_r = 19'(c);
      #1;
      s = 0;
      for (int j = 0; j < 4; j++)
        s += longint'(7 * code_val(dig_r[j].hi) + code_val(dig_r[j].lo)) * (64'sd1 << (5 * j));
      chk("R3", s, c);
    end

    // R2: random wide operands
    for (int n = 0; n < 1500; n++)
      run_both(rnd19(), rnd19(), 0, 0, "R2");

    $display("test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end

endmodule